// File: doc/BRIEF.md
# Global Barrier and Interrupt Node

This block is the per-node logic of a low-latency global signalling network that carries several independent one-bit channels. Each channel takes this node's own contribution and the wires from up to six neighbouring nodes, merges them, and drives the merged level onward to the rest of the machine. Each channel is configured on its own to act either as an interrupt line, where any contributor raises it (OR), or as a barrier line, where it goes high only when every contributor is ready (AND).

The local contribution is held in a sticky bit. It stays set once written, so one wire is enough for a complete barrier. In AND mode the bit clears itself after the merged level has been seen high and then low again, which leaves the channel ready for the next barrier. Neighbour wires arrive with no clock relation to this node and pass through two-flop synchronizers. A partition mask chooses which neighbour wires belong to this node's partition. A masked wire contributes the neutral value of its channel's mode. System-level configuration decides which channels an unprivileged user may drive. A rising merged level on an OR channel can raise an interrupt.

Top module: `gbar_node`

## Requirements
- R1: After reset all sticky bits, merged results, pending flags, interrupt enables, channel modes, the partition mask and the user channel mask are 0, so `up_out` and `irq` are low.
- R2: A change on a neighbour wire reaches `up_out` on the third rising clock edge after it is applied: two synchronizer stages, then one result register.
- R3: A channel whose mode bit is 0 (OR) has a merged result equal to its sticky bit ORed with all of its enabled neighbour wires.
- R4: A channel whose mode bit is 1 (AND) has a merged result equal to its sticky bit ANDed with all of its enabled neighbour wires, so the result is never high while the sticky bit is clear.
- R5: Neighbour wire p of channel c is enabled by partition bit c*6+p. A masked wire has no effect: it counts as 1 in AND mode and as 0 in OR mode.
- R6: Writing 1 to control bit c sets sticky bit c, and writing 1 to control bit 4+c clears it. In OR mode the sticky bit changes for no other reason.
- R7: In AND mode, once the merged result has been high with the sticky bit set and then falls, the sticky bit clears on the next clock edge.
- R8: The pending flag of a channel is set on the edge where its merged result rises, but only in OR mode. Writing 1 to control bit 12+c clears it. `irq` is the OR over channels of pending AND interrupt enable.
- R9: The mode (address 0), partition (address 1) and user channel mask (address 2) registers change only on writes with `cfg_sys` high.
- R10: A control write with `cfg_sys` low acts only on channels whose user mask bit is 1. A write with `cfg_sys` high acts on all channels.
- R11: `cfg_rdata` follows `cfg_addr` with no clock delay. At address 3 it returns sticky bits in [3:0], merged results in [7:4], interrupt enables in [11:8] and pending flags in [15:12]. A control write loads bits [11:8] into the permitted interrupt enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Node clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nbr_in | input | 24 | Neighbour wires, bit c*6+p is port p of channel c; asynchronous |
| up_out | output | 4 | Merged level per channel, driven onward |
| irq | output | 1 | Interrupt request |
| cfg_we | input | 1 | Register write strobe |
| cfg_sys | input | 1 | Access carries system privilege |
| cfg_addr | input | 2 | Register address: 0 mode, 1 partition, 2 user mask, 3 control/status |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |

## Verification
A neighbour wire is due at `up_out` three edges after it is driven. A sticky or partition write shows in the result one edge after the write edge. A pending flag rises on the same edge as its result. An AND-mode sticky bit drops one edge after its result falls. Reads are combinational. The bench drives inputs just after the falling edge and keeps a behavioural model that steps on each rising edge. It compares `up_out`, `irq` and `cfg_rdata` with the model at every falling edge. Directed checks sample exactly on the edge counts above, and one edge before where a latency matters.

// File: rtl/gbar_pkg.sv
// Package: shared register addresses for the global barrier node.
// Assumes a two-bit register address space.
package gbar_pkg;
    typedef enum logic [1:0] {
        ADDR_MODE = 2'd0,
        ADDR_PART = 2'd1,
        ADDR_UEN  = 2'd2,
        ADDR_CTRL = 2'd3
    } gbar_addr_e;
endpackage

// File: rtl/gbar_sync.sv
// Multi-stage synchronizer for a vector of unrelated asynchronous bits.
// Assumes each bit is a level that stays stable well beyond a few clocks.
module gbar_sync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gbar_combine.sv
// Per-channel merge of the sticky bit with the partition-enabled neighbour
// wires, in AND or OR mode. Purely combinational.
// Assumes the neighbour wires are already synchronous.
module gbar_combine #(
    parameter int NCH   = 4,
    parameter int NPORT = 6
) (
    input  logic [NCH*NPORT-1:0] nbr_s,
    input  logic [NCH*NPORT-1:0] part,
    input  logic [NCH-1:0]       mode_and,
    input  logic [NCH-1:0]       sticky,
    output logic [NCH-1:0]       merged
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [NPORT-1:0] ports;
        logic [NPORT-1:0] en;
        logic             v_and;
        logic             v_or;
        assign ports = nbr_s[c*NPORT +: NPORT];
        assign en    = part[c*NPORT +: NPORT];
        // A masked port is forced to the neutral value of the mode.
        assign v_and = sticky[c] & (&(ports | ~en));
        assign v_or  = sticky[c] | (|(ports & en));
        assign merged[c] = mode_and[c] ? v_and : v_or;
    end
endmodule

// File: rtl/gbar_chan_state.sv
// Per-channel state: merged result register, sticky bit with AND-mode
// self-clear, and the OR-mode rising-edge pending flag.
// Assumes the set, clear and pending-clear strobes are already permission-masked.
module gbar_chan_state #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] merged,
    input  logic [NCH-1:0] mode_and,
    input  logic [NCH-1:0] set_ch,
    input  logic [NCH-1:0] clr_ch,
    input  logic [NCH-1:0] pclr_ch,
    output logic [NCH-1:0] res_q,
    output logic [NCH-1:0] sticky_q,
    output logic [NCH-1:0] pend_q
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic res_r, stk_r, seen_r, pend_r;
        logic stk_n, seen_n, pend_n, autoclr;

        // Next-state rules for the sticky, seen and pending bits.
        always_comb begin
            autoclr = mode_and[c] & seen_r & ~res_r;
            stk_n   = stk_r;
            if (autoclr)   stk_n = 1'b0;
            if (clr_ch[c]) stk_n = 1'b0;
            if (set_ch[c]) stk_n = 1'b1;
            seen_n  = stk_n & mode_and[c] & (seen_r | res_r);
            pend_n  = (pend_r & ~pclr_ch[c]) | (~mode_and[c] & merged[c] & ~res_r);
        end

        // Register the channel state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_r  <= 1'b0;
                stk_r  <= 1'b0;
                seen_r <= 1'b0;
                pend_r <= 1'b0;
            end else begin
                res_r  <= merged[c];
                stk_r  <= stk_n;
                seen_r <= seen_n;
                pend_r <= pend_n;
            end
        end

        assign res_q[c]    = res_r;
        assign sticky_q[c] = stk_r;
        assign pend_q[c]   = pend_r;
    end
endmodule

// File: rtl/gbar_regs.sv
// Configuration and control registers with privilege checks and read mux.
// Assumes 4*NCH and NCH*NPORT both fit in DW.
module gbar_regs
    import gbar_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int NPORT = 6,
    parameter int DW    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_sys,
    input  logic [1:0]           cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    output logic [DW-1:0]        cfg_rdata,
    input  logic [NCH-1:0]       sticky_q,
    input  logic [NCH-1:0]       res_q,
    input  logic [NCH-1:0]       pend_q,
    output logic [NCH-1:0]       mode_q,
    output logic [NCH*NPORT-1:0] part_q,
    output logic [NCH-1:0]       uen_q,
    output logic [NCH-1:0]       irqen_q,
    output logic [NCH-1:0]       set_ch,
    output logic [NCH-1:0]       clr_ch,
    output logic [NCH-1:0]       pclr_ch
);
    localparam int PW = NCH * NPORT;

    gbar_addr_e      addr;
    logic [NCH-1:0]  allow;
    logic            ctrl_we;
    logic            sys_we;
    logic            unused_wdata;

    assign addr    = gbar_addr_e'(cfg_addr);
    assign allow   = cfg_sys ? {NCH{1'b1}} : uen_q;
    assign ctrl_we = cfg_we && (addr == ADDR_CTRL);
    assign sys_we  = cfg_we && cfg_sys;
    assign unused_wdata = ^cfg_wdata;

    // Decode the control strobes, limited to permitted channels.
    assign set_ch  = ctrl_we ? (cfg_wdata[NCH-1:0]       & allow) : '0;
    assign clr_ch  = ctrl_we ? (cfg_wdata[2*NCH-1:NCH]   & allow) : '0;
    assign pclr_ch = ctrl_we ? (cfg_wdata[4*NCH-1:3*NCH] & allow) : '0;

    // Hold the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            part_q  <= '0;
            uen_q   <= '0;
            irqen_q <= '0;
        end else begin
            if (sys_we && addr == ADDR_MODE) mode_q <= cfg_wdata[NCH-1:0];
            if (sys_we && addr == ADDR_PART) part_q <= cfg_wdata[PW-1:0];
            if (sys_we && addr == ADDR_UEN)  uen_q  <= cfg_wdata[NCH-1:0];
            if (ctrl_we)
                irqen_q <= (irqen_q & ~allow) | (cfg_wdata[3*NCH-1:2*NCH] & allow);
        end
    end

    // Select the read data for the current address.
    always_comb begin
        cfg_rdata = '0;
        case (addr)
            ADDR_MODE: cfg_rdata[NCH-1:0] = mode_q;
            ADDR_PART: cfg_rdata[PW-1:0]  = part_q;
            ADDR_UEN:  cfg_rdata[NCH-1:0] = uen_q;
            default: begin
                cfg_rdata[NCH-1:0]       = sticky_q;
                cfg_rdata[2*NCH-1:NCH]   = res_q;
                cfg_rdata[3*NCH-1:2*NCH] = irqen_q;
                cfg_rdata[4*NCH-1:3*NCH] = pend_q;
            end
        endcase
    end
endmodule

// File: rtl/gbar_node.sv
// Top of the global barrier/interrupt node: synchronizes neighbour wires,
// merges them per channel and exposes control and status registers.
// Assumes neighbour wires are asynchronous levels; reset is synchronous.
module gbar_node #(
    parameter int NCH    = 4,
    parameter int NPORT  = 6,
    parameter int DW     = 32,
    parameter int STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*NPORT-1:0] nbr_in,
    output logic [NCH-1:0]       up_out,
    output logic                 irq,
    input  logic                 cfg_we,
    input  logic                 cfg_sys,
    input  logic [1:0]           cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    output logic [DW-1:0]        cfg_rdata
);
    localparam int PW = NCH * NPORT;

    logic [PW-1:0]  nbr_s;
    logic [PW-1:0]  part_q;
    logic [NCH-1:0] mode_q, uen_q, irqen_q;
    logic [NCH-1:0] sticky_q, res_q, pend_q, merged;
    logic [NCH-1:0] set_ch, clr_ch, pclr_ch;

    gbar_sync #(.W(PW), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(nbr_in), .q(nbr_s)
    );

    gbar_combine #(.NCH(NCH), .NPORT(NPORT)) u_comb (
        .nbr_s(nbr_s), .part(part_q), .mode_and(mode_q),
        .sticky(sticky_q), .merged(merged)
    );

    gbar_chan_state #(.NCH(NCH)) u_state (
        .clk(clk), .rst_n(rst_n), .merged(merged), .mode_and(mode_q),
        .set_ch(set_ch), .clr_ch(clr_ch), .pclr_ch(pclr_ch),
        .res_q(res_q), .sticky_q(sticky_q), .pend_q(pend_q)
    );

    gbar_regs #(.NCH(NCH), .NPORT(NPORT), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sys(cfg_sys),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .sticky_q(sticky_q), .res_q(res_q), .pend_q(pend_q),
        .mode_q(mode_q), .part_q(part_q), .uen_q(uen_q), .irqen_q(irqen_q),
        .set_ch(set_ch), .clr_ch(clr_ch), .pclr_ch(pclr_ch)
    );

    assign up_out = res_q;
    assign irq    = |(pend_q & irqen_q);
endmodule

// File: rtl/gbar_node_chk.sv
// Checker for gbar_node: temporal properties over its internal state,
// attached with bind. Assumes synchronous active-low reset.
module gbar_node_chk #(
    parameter int NCH   = 4,
    parameter int NPORT = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic                 cfg_sys,
    input logic [1:0]           cfg_addr,
    input logic [NCH-1:0]       mode_q,
    input logic [NCH*NPORT-1:0] part_q,
    input logic [NCH-1:0]       sticky_q,
    input logic [NCH-1:0]       res_q,
    input logic [NCH-1:0]       pend_q
);
    assert_or_sticky_forces_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~res_q & ~$past(mode_q) & $past(sticky_q)) == '0));

    assert_and_needs_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((res_q & $past(mode_q) & ~$past(sticky_q)) == '0));

    assert_or_sticky_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(cfg_we && cfg_addr == 2'd3) ||
                  (($past(sticky_q) & ~sticky_q & ~$past(mode_q)) == '0)));

    assert_pend_only_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & $past(mode_q)) == '0));

    assert_sys_regs_guarded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sys) |=> ($stable(mode_q) && $stable(part_q)));
endmodule

bind gbar_node gbar_node_chk #(.NCH(NCH), .NPORT(NPORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sys(cfg_sys),
    .cfg_addr(cfg_addr), .mode_q(mode_q), .part_q(part_q),
    .sticky_q(sticky_q), .res_q(res_q), .pend_q(pend_q)
);

// File: tb/gbar_node_tb.sv
module gbar_node_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] nbr_in = '0;
    logic [3:0]  up_out;
    logic        irq;
    logic        cfg_we = 1'b0;
    logic        cfg_sys = 1'b0;
    logic [1:0]  cfg_addr = 2'd3;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gbar_node u_dut (
        .clk(clk), .rst_n(rst_n), .nbr_in(nbr_in), .up_out(up_out), .irq(irq),
        .cfg_we(cfg_we), .cfg_sys(cfg_sys), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    // Behavioural model of the requirements.
    logic [23:0] h1, h2, m_part;
    logic [3:0]  m_mode, m_uen, m_ien, m_stk, m_seen, m_res, m_pend;
    logic [3:0]  allow, setv, clrv, pclrv, nres, nstk, nseen, npend;
    logic        wctl, v;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = '0; h2 = '0; m_part = '0; m_mode = '0; m_uen = '0; m_ien = '0;
            m_stk = '0; m_seen = '0; m_res = '0; m_pend = '0;
        end else begin
            allow = cfg_sys ? 4'hF : m_uen;
            wctl  = cfg_we && cfg_addr == 2'd3;
            setv  = wctl ? cfg_wdata[3:0] & allow : 4'h0;
            clrv  = wctl ? cfg_wdata[7:4] & allow : 4'h0;
            pclrv = wctl ? cfg_wdata[15:12] & allow : 4'h0;
            for (int c = 0; c < 4; c++) begin
                v = m_stk[c];
                for (int p = 0; p < 6; p++) begin
                    if (m_part[c*6+p]) begin
                        if (m_mode[c]) v = v & h2[c*6+p];
                        else           v = v | h2[c*6+p];
                    end
                end
                nres[c] = v;
                nstk[c] = m_stk[c];
                if (m_mode[c] && m_seen[c] && !m_res[c]) nstk[c] = 1'b0;
                if (clrv[c]) nstk[c] = 1'b0;
                if (setv[c]) nstk[c] = 1'b1;
                nseen[c] = nstk[c] && m_mode[c] && (m_seen[c] || m_res[c]);
                npend[c] = (m_pend[c] && !pclrv[c]) || (!m_mode[c] && v && !m_res[c]);
            end
            if (wctl) m_ien = (m_ien & ~allow) | (cfg_wdata[11:8] & allow);
            if (cfg_we && cfg_sys && cfg_addr == 2'd0) m_mode = cfg_wdata[3:0];
            if (cfg_we && cfg_sys && cfg_addr == 2'd1) m_part = cfg_wdata[23:0];
            if (cfg_we && cfg_sys && cfg_addr == 2'd2) m_uen  = cfg_wdata[3:0];
            m_res = nres; m_stk = nstk; m_seen = nseen; m_pend = npend;
            h2 = h1; h1 = nbr_in;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: exp_rd = {28'h0, m_mode};
            2'd1: exp_rd = {8'h0, m_part};
            2'd2: exp_rd = {28'h0, m_uen};
            default: exp_rd = {16'h0, m_pend, m_ien, m_res, m_stk};
        endcase
    endfunction

    // Compare against the model at every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(up_out == m_res, "R2 up_out vs model", {28'h0, up_out}, {28'h0, m_res});
            chk(irq == |(m_pend & m_ien), "R8 irq vs model", {31'h0, irq}, {31'h0, |(m_pend & m_ien)});
            chk(cfg_rdata == exp_rd(cfg_addr), "R11 rdata vs model", cfg_rdata, exp_rd(cfg_addr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic sys);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_sys = sys;
        @(negedge clk); #1;
        cfg_we = 1'b0; cfg_addr = 2'd3; cfg_sys = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        cfg_addr = a; #1;
        d = cfg_rdata;
        cfg_addr = 2'd3;
    endtask

    task automatic negs(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(up_out == 4'h0 && irq == 1'b0, "R1 outputs after reset", {27'h0, irq, up_out}, 32'h0);
        rd(2'd3, r); chk(r == 32'h0, "R1 status after reset", r, 32'h0);
        rd(2'd0, r); chk(r == 32'h0, "R1 mode after reset", r, 32'h0);
        rd(2'd1, r); chk(r == 32'h0, "R1 partition after reset", r, 32'h0);

        wr(2'd0, 32'h5, 1'b1);
        wr(2'd1, 32'hFF_FFFF, 1'b1);
        wr(2'd2, 32'hF, 1'b1);
        // R9: unprivileged writes to system registers are ignored
        wr(2'd0, 32'hA, 1'b0);
        rd(2'd0, r); chk(r == 32'h5, "R9 mode kept", r, 32'h5);
        wr(2'd2, 32'h0, 1'b0);
        rd(2'd2, r); chk(r == 32'hF, "R9 user mask kept", r, 32'hF);

        wr(2'd3, 32'h200, 1'b0);
        // R2/R3: OR channel 1, port 3 (bit 9)
        @(negedge clk); #1 nbr_in[9] = 1'b1;
        negs(2); chk(up_out[1] == 1'b0, "R2 not yet after two edges", {31'h0, up_out[1]}, 32'h0);
        negs(1); chk(up_out[1] == 1'b1, "R3 OR result on third edge", {31'h0, up_out[1]}, 32'h1);
        chk(irq == 1'b1, "R8 irq on rise", {31'h0, irq}, 32'h1);
        rd(2'd3, r); chk(r == 32'h2220, "R11 status layout", r, 32'h2220);
        wr(2'd3, 32'h2200, 1'b0);
        chk(irq == 1'b0, "R8 pending cleared", {31'h0, irq}, 32'h0);
        negs(3); chk(irq == 1'b0, "R8 no re-raise while high", {31'h0, irq}, 32'h0);

        // R5: mask port 3 of channel 1
        wr(2'd1, 32'hFF_FDFF, 1'b1);
        negs(1); chk(up_out[1] == 1'b0, "R5 masked OR port ignored", {31'h0, up_out[1]}, 32'h0);

        // R4: AND channel 0
        @(negedge clk); #1 nbr_in[5:0] = 6'h3F;
        negs(4); chk(up_out[0] == 1'b0, "R4 AND without sticky", {31'h0, up_out[0]}, 32'h0);
        wr(2'd3, 32'h301, 1'b0);
        negs(1); chk(up_out[0] == 1'b1, "R4 AND with sticky", {31'h0, up_out[0]}, 32'h1);
        chk(irq == 1'b0, "R8 no irq in AND mode", {31'h0, irq}, 32'h0);

        // R7: drop a port, result falls, sticky clears one edge later
        @(negedge clk); #1 nbr_in[2] = 1'b0;
        negs(3); chk(up_out[0] == 1'b0, "R7 result falls", {31'h0, up_out[0]}, 32'h0);
        chk(cfg_rdata[0] == 1'b1, "R7 sticky still set", {31'h0, cfg_rdata[0]}, 32'h1);
        negs(1); chk(cfg_rdata[0] == 1'b0, "R7 sticky self-cleared", {31'h0, cfg_rdata[0]}, 32'h0);
        @(negedge clk); #1 nbr_in[2] = 1'b1;
        negs(4); chk(up_out[0] == 1'b0, "R7 channel rearmed low", {31'h0, up_out[0]}, 32'h0);

        // R5: masked AND ports act as 1
        wr(2'd1, 32'hFF_FDC0, 1'b1);
        @(negedge clk); #1 nbr_in[0] = 1'b0;
        negs(3);
        wr(2'd3, 32'h1, 1'b0);
        negs(1); chk(up_out[0] == 1'b1, "R5 masked AND ports neutral", {31'h0, up_out[0]}, 32'h1);
        wr(2'd3, 32'h10, 1'b0);
        negs(1); chk(up_out[0] == 1'b0, "R6 clear sticky", {31'h0, up_out[0]}, 32'h0);

        // R6: OR channel 3 holds sticky
        wr(2'd3, 32'h8, 1'b0);
        negs(1); chk(up_out[3] == 1'b1, "R6 sticky drives OR", {31'h0, up_out[3]}, 32'h1);
        negs(10); chk(up_out[3] == 1'b1 && cfg_rdata[3] == 1'b1, "R6 sticky holds",
                      {30'h0, cfg_rdata[3], up_out[3]}, 32'h3);
        wr(2'd3, 32'h80, 1'b0);
        negs(1); chk(up_out[3] == 1'b0, "R6 sticky cleared", {31'h0, up_out[3]}, 32'h0);

        // R10: user mask limits control writes
        wr(2'd2, 32'h1, 1'b1);
        wr(2'd3, 32'h4, 1'b0);
        negs(1); chk(cfg_rdata[2] == 1'b0, "R10 user write to masked channel", {31'h0, cfg_rdata[2]}, 32'h0);
        wr(2'd3, 32'h1, 1'b0);
        negs(1); chk(cfg_rdata[0] == 1'b1, "R10 user write to allowed channel", {31'h0, cfg_rdata[0]}, 32'h1);
        wr(2'd3, 32'h4, 1'b1);
        negs(1); chk(cfg_rdata[2] == 1'b1, "R10 system write any channel", {31'h0, cfg_rdata[2]}, 32'h1);

        negs(4);
        finish_up();
    end
endmodule